// File: doc/BRIEF.md
# Shaped Keying Envelope Scaler

This block multiplies a stream of 12-bit two's complement samples by a 12-bit unsigned gain. The gain comes from one of three places. It can be unity, which bypasses the multiplier. It can be a static value held on a user input. It can be an envelope counter that rises and falls under the control of a keying input. The scaled sample is registered once, so the output always follows the input by one clock.

The envelope counter is paced by an 8-bit rate prescaler. The prescaler loads the rate value, counts down to zero, emits one tick and then reloads. Each tick moves the envelope by one code: up towards 4095 while the synchronized keying input is high, and down towards 0 while it is low. The counter stops at both ends and never wraps. When the keying level changes in the middle of a ramp, the ramp turns round from the code it has reached. The keying input is asynchronous and passes through two flip-flops before the counter uses it.

The envelope counter runs in every mode. Switching to the envelope source therefore picks up whatever code the counter holds at that moment.

Top module: `kenv_top`

## Requirements
- R1: When `shape_en_i` is 0, `sample_o` equals the value `sample_i` had one clock earlier.
- R2: When `shape_en_i` is 1 and `ramp_src_i` is 0, the gain is `user_gain_i`.
- R3: When `shape_en_i` is 1 and `ramp_src_i` is 1, the gain is the current envelope code.
- R4: With product p = sample × gain, the registered result is floor((p + floor(p/4096) + 2048) / 4096), clamped to [-2048, 2047]. A gain of 4095 therefore returns the sample unchanged, and a gain of 0 returns 0.
- R5: After the first prescaler load, a tick occurs once every rate+1 clocks. With a rate of 0, a tick occurs on every clock.
- R6: A new rate value is taken only when the prescaler reloads, which is the cycle of a tick or the first cycle after reset.
- R7: On each tick with the synchronized key high, the envelope rises by 1. It stays at 4095 once it gets there.
- R8: On each tick with the synchronized key low, the envelope falls by 1. It stays at 0 once it gets there.
- R9: A change of key level during a ramp reverses the direction of the ramp from the code already reached, with no jump.
- R10: The key passes through two flip-flops, so a change on `key_i` is seen by the envelope two clocks later.
- R11: While reset is asserted, the output, the envelope and the key synchronizer are 0 and the prescaler is unloaded. The first clock after reset loads the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 1 | Asynchronous keying level: high ramps the envelope up, low ramps it down |
| shape_en_i | input | 1 | 1 routes the sample through the multiplier; 0 bypasses it |
| ramp_src_i | input | 1 | With the multiplier enabled: 1 selects the envelope as gain, 0 selects the user gain |
| rate_i | input | 8 | Prescaler reload value N; the tick interval is N+1 clocks |
| user_gain_i | input | 12 | Static gain, used when the user source is selected |
| sample_i | input | 12 | Signed input sample |
| sample_o | output | 12 | Signed scaled sample, registered |

## Verification
The checker runs on every clock and covers four things:
- the prescaler reloads with the rate present at the tick, and cannot tick while its count is above 1;
- the envelope holds between ticks, moves by exactly one code in the direction the synchronized key sets, and stays put at both ends;
- the bypass path returns the sample unchanged;
- the unity and zero gain cases give the sample and zero.

Other behaviours can only be shown by the bench's scenarios, which compare every output against a cycle model built from the requirements. These are:
- the exact rounded products for intermediate gains;
- the two-clock key latency;
- ramp reversal partway through a ramp;
- a rate change that waits for the next reload;
- complete rises and falls across all 4096 codes.

// File: rtl/kenv_pkg.sv
package kenv_pkg;

    // Gain source picked by the enable and select inputs
    typedef enum logic [1:0] {
        GSRC_UNITY = 2'd0,
        GSRC_USER  = 2'd1,
        GSRC_ENV   = 2'd2
    } gsrc_e;

    function automatic gsrc_e pick_source(input logic enable, input logic env_sel);
        gsrc_e src;
        if (!enable) begin
            src = GSRC_UNITY;
        end else if (env_sel) begin
            src = GSRC_ENV;
        end else begin
            src = GSRC_USER;
        end
        return src;
    endfunction

endpackage

// File: rtl/kenv_sync.sv
module kenv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        end else begin
            st_d.chain[0] = async_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/kenv_prescaler.sv
module kenv_prescaler #(
    parameter int RATE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o,
    output logic              loaded_o,
    output logic [RATE_W-1:0] count_o
);
    typedef struct packed {
        logic              loaded;
        logic [RATE_W-1:0] count;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       tick;

    assign tick = st_q.loaded && (st_q.count == '0);

    always_comb begin
        st_d = st_q;
        if (!st_q.loaded) begin
            // first load after reset
            st_d.loaded = 1'b1;
            st_d.count  = rate_i;
        end else if (tick) begin
            st_d.count = rate_i;
        end else begin
            st_d.count = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o   = tick;
    assign loaded_o = st_q.loaded;
    assign count_o  = st_q.count;
endmodule

// File: rtl/kenv_ramp.sv
module kenv_ramp #(
    parameter int AMP_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             up_i,
    output logic [AMP_W-1:0] amp_o
);
    localparam logic [AMP_W-1:0] AMP_TOP = {AMP_W{1'b1}};

    typedef struct packed {
        logic [AMP_W-1:0] amp;
    } ramp_state_t;

    ramp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (up_i) begin
                if (st_q.amp != AMP_TOP) begin
                    st_d.amp = st_q.amp + 1'b1;
                end
            end else begin
                if (st_q.amp != '0) begin
                    st_d.amp = st_q.amp - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign amp_o = st_q.amp;
endmodule

// File: rtl/kenv_scaler.sv
module kenv_scaler
    import kenv_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  gsrc_e                    src_i,
    input  logic [AMP_W-1:0]         user_gain_i,
    input  logic [AMP_W-1:0]         env_gain_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic signed [DATA_W-1:0] sample_o
);
    localparam int PW = DATA_W + AMP_W + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1 << (AMP_W - 1));
    localparam logic signed [PW-1:0] QMAX = PW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] QMIN = -QMAX - PW'(1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } scl_state_t;

    scl_state_t st_d, st_q;

    logic [AMP_W-1:0]        gain;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    acc;
    logic signed [PW-1:0]    quot;
    logic signed [DATA_W-1:0] scaled;

    always_comb begin
        unique case (src_i)
            GSRC_USER: gain = user_gain_i;
            GSRC_ENV:  gain = env_gain_i;
            default:   gain = '0;
        endcase
    end

    // divide by 2^AMP_W - 1 approximated as (p + p/2^AMP_W) / 2^AMP_W, rounded
    always_comb begin
        prod = PW'(sample_i) * $signed({1'b0, gain});
        acc  = prod + (prod >>> AMP_W) + HALF;
        quot = acc >>> AMP_W;
        if (quot > QMAX) begin
            scaled = QMAX[DATA_W-1:0];
        end else if (quot < QMIN) begin
            scaled = QMIN[DATA_W-1:0];
        end else begin
            scaled = quot[DATA_W-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        if (src_i == GSRC_UNITY) begin
            st_d.data = sample_i;
        end else begin
            st_d.data = scaled;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = $signed(st_q.data);
endmodule

// File: rtl/kenv_top.sv
module kenv_top
    import kenv_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int AMP_W     = 12,
    parameter int RATE_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     key_i,
    input  logic                     shape_en_i,
    input  logic                     ramp_src_i,
    input  logic [RATE_W-1:0]        rate_i,
    input  logic [AMP_W-1:0]         user_gain_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic signed [DATA_W-1:0] sample_o
);
    logic              key_sync;
    logic              tick;
    logic              pre_loaded;
    logic [RATE_W-1:0] pre_count;
    logic [AMP_W-1:0]  env_amp;
    gsrc_e             gsrc;

    assign gsrc = pick_source(shape_en_i, ramp_src_i);

    kenv_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (key_i),
        .sync_o  (key_sync)
    );

    kenv_prescaler #(.RATE_W(RATE_W)) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rate_i   (rate_i),
        .tick_o   (tick),
        .loaded_o (pre_loaded),
        .count_o  (pre_count)
    );

    kenv_ramp #(.AMP_W(AMP_W)) u_ramp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .up_i   (key_sync),
        .amp_o  (env_amp)
    );

    kenv_scaler #(.DATA_W(DATA_W), .AMP_W(AMP_W)) u_scl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_i       (gsrc),
        .user_gain_i (user_gain_i),
        .env_gain_i  (env_amp),
        .sample_i    (sample_i),
        .sample_o    (sample_o)
    );
endmodule

// File: rtl/kenv_checker.sv
module kenv_checker #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 12,
    parameter int RATE_W = 8
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     shape_en_i,
    input logic                     ramp_src_i,
    input logic [RATE_W-1:0]        rate_i,
    input logic [AMP_W-1:0]         user_gain_i,
    input logic signed [DATA_W-1:0] sample_i,
    input logic signed [DATA_W-1:0] sample_o,
    input logic                     tick_i,
    input logic [RATE_W-1:0]        count_i,
    input logic                     key_sync_i,
    input logic [AMP_W-1:0]         amp_i
);
    localparam logic [AMP_W-1:0] TOP = {AMP_W{1'b1}};

    assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shape_en_i |=> sample_o == $past(sample_i));

    assert_user_unity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shape_en_i && !ramp_src_i && user_gain_i == TOP) |=> sample_o == $past(sample_i));

    assert_env_unity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shape_en_i && ramp_src_i && amp_i == TOP) |=> sample_o == $past(sample_i));

    assert_zero_gain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shape_en_i && !ramp_src_i && user_gain_i == '0) |=> sample_o == '0);

    assert_no_early_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i > RATE_W'(1)) |=> !tick_i);

    assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> count_i == $past(rate_i));

    assert_hold_between_ticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(amp_i));

    assert_step_up_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && key_sync_i && amp_i != TOP) |=> amp_i == $past(amp_i) + AMP_W'(1));

    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (amp_i == TOP && key_sync_i) |=> amp_i == TOP);

    assert_step_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !key_sync_i && amp_i != '0) |=> amp_i == $past(amp_i) - AMP_W'(1));

    assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (amp_i == '0 && !key_sync_i) |=> amp_i == '0);
endmodule

bind kenv_top kenv_checker #(.DATA_W(DATA_W), .AMP_W(AMP_W), .RATE_W(RATE_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shape_en_i  (shape_en_i),
    .ramp_src_i  (ramp_src_i),
    .rate_i      (rate_i),
    .user_gain_i (user_gain_i),
    .sample_i    (sample_i),
    .sample_o    (sample_o),
    .tick_i      (tick),
    .count_i     (pre_count),
    .key_sync_i  (key_sync),
    .amp_i       (env_amp)
);

// File: tb/tb_kenv_top.sv
module tb_kenv_top;
    logic              clk = 1'b0;
    logic              rst_ni;
    logic              key_i;
    logic              shape_en_i;
    logic              ramp_src_i;
    logic [7:0]        rate_i;
    logic [11:0]       user_gain_i;
    logic signed [11:0] sample_i;
    logic signed [11:0] sample_o;

    always #4 clk = ~clk;   // 125 MHz

    kenv_top dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .key_i       (key_i),
        .shape_en_i  (shape_en_i),
        .ramp_src_i  (ramp_src_i),
        .rate_i      (rate_i),
        .user_gain_i (user_gain_i),
        .sample_i    (sample_i),
        .sample_o    (sample_o)
    );

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    item_t sbq[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // cycle model built from the requirements
    bit m_loaded, m_s1, m_s2;
    int m_cnt, m_amp;

    function automatic int scale(int x, int g);   // R4
        int p, q;
        p = x * g;
        q = (p + (p >>> 12) + 2048) >>> 12;
        if (q > 2047) q = 2047;
        if (q < -2048) q = -2048;
        return q;
    endfunction

    // driver: push the output expected after the coming edge, then advance the model
    task automatic step(input string tag);
        item_t it;
        bit    tk;
        if (!shape_en_i)     it.exp = int'(sample_i);                          // R1
        else if (ramp_src_i) it.exp = scale(int'(sample_i), m_amp);            // R3
        else                 it.exp = scale(int'(sample_i), int'(user_gain_i)); // R2
        it.tag = tag;
        sbq.push_back(it);
        tk = m_loaded && (m_cnt == 0);                       // R5
        if (tk) begin
            if (m_s2 && m_amp < 4095) m_amp++;               // R7
            else if (!m_s2 && m_amp > 0) m_amp--;            // R8
        end
        if (!m_loaded || tk) begin m_cnt = int'(rate_i); m_loaded = 1'b1; end  // R6
        else m_cnt--;
        m_s2 = m_s1;                                          // R10
        m_s1 = key_i;
        @(negedge clk);
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_run++;
            if (int'(sample_o) != it.exp) begin
                n_fail++;
                $display("FAIL %s: sample_o actual %0d expected %0d at %0t",
                         it.tag, int'(sample_o), it.exp, $time);
            end
        end
    end

    initial begin
        rst_ni = 1'b0; key_i = 1'b0; shape_en_i = 1'b0; ramp_src_i = 1'b0;
        rate_i = 8'd0; user_gain_i = 12'd0; sample_i = 12'sd0;
        m_loaded = 0; m_s1 = 0; m_s2 = 0; m_cnt = 0; m_amp = 0;
        sample_i = 12'sd1234;
        repeat (3) @(negedge clk);
        n_run++;                                              // R11 reset state
        if (sample_o !== 12'sd0) begin
            n_fail++;
            $display("FAIL R11: reset output actual %0d expected 0", int'(sample_o));
        end
        rst_ni = 1'b1;

        // R11: envelope starts at zero
        shape_en_i = 1'b1; ramp_src_i = 1'b1; sample_i = 12'sd2047;
        step("R11");

        // R1: bypass
        shape_en_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sample_i = 12'(i * 611 - 2048);
            step("R1");
        end

        // R2 / R4: user gain, several patterns
        shape_en_i = 1'b1; ramp_src_i = 1'b0;
        for (int i = 0; i < 24; i++) begin
            sample_i    = 12'(i * 397 - 2048);
            user_gain_i = 12'(i * 733 + 1);
            step("R2");
        end
        user_gain_i = 12'd4095;
        sample_i = -12'sd2048; step("R4");
        sample_i = 12'sd2047;  step("R4");
        sample_i = -12'sd1;    step("R4");
        user_gain_i = 12'd0;
        sample_i = -12'sd2048; step("R4");
        sample_i = 12'sd2047;  step("R4");
        user_gain_i = 12'd2048;
        sample_i = -12'sd2048; step("R4");

        // R7 / R10: full rise at rate 0, then hold at the top
        ramp_src_i = 1'b1; rate_i = 8'd0; sample_i = 12'sd2047;
        key_i = 1'b1;
        steps(4, "R10");
        steps(4100, "R7");
        sample_i = -12'sd2048;
        steps(20, "R7");

        // R8 / R5: full fall at rate 2
        rate_i = 8'd2; key_i = 1'b0;
        steps(4, "R10");
        steps(4096 * 3 + 10, "R8");

        // R9: reversal mid-ramp at rate 1
        rate_i = 8'd1; key_i = 1'b1; sample_i = 12'sd2047;
        steps(600, "R9");
        key_i = 1'b0;
        steps(300, "R9");
        key_i = 1'b1;
        steps(200, "R9");

        // R6 / R5: rate change takes hold at next reload
        rate_i = 8'd9;
        steps(23, "R5");
        rate_i = 8'd3;
        steps(40, "R6");
        rate_i = 8'd255;
        steps(600, "R6");

        // R3: switch to envelope after running on user source
        ramp_src_i = 1'b0; user_gain_i = 12'd100;
        steps(30, "R2");
        ramp_src_i = 1'b1;
        steps(10, "R3");

        @(posedge clk); #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule